// File: doc/BRIEF.md
# Recovered Clock Jitter and Time-Error Monitor

This block grades a recovered TDM line clock against a fast system clock that serves as the time base. The block counts the system clock with a free-running timestamp counter. It detects each rising edge of the monitored clock, and it takes the difference between successive edge timestamps as one bit interval. Over a measurement period of a programmed number of intervals, the block keeps the shortest and the longest interval. When the period closes, it reports their spread as peak-to-peak jitter, in unit intervals, as a fixed-point number.

Alongside the jitter measurement, the block accumulates a time-error sequence. Each new sample is the previous sample plus the difference between the measured interval and a reference interval. The reference interval is either the nominal unit interval of the selected line type, or the latest interval measured on a second (master) clock input. The second choice gives a relative time-error figure. For an observation length of tau samples, the block slides a window across every run of tau consecutive time-error samples and reports the largest peak-to-peak excursion found (MTIE, or MRTIE in relative mode).

A start pulse clears all results and arms a new measurement. A done flag marks the point from which the results are final.

Top module: `jitter_mtie_monitor`

## Requirements
- R1: After reset, done=0, mtie=0, jit_uipp=0, int_max=0 and int_min is all ones.
- R2: An interval is the number of reference cycles between successive rising edges of mon_clk. int_min and int_max report the smallest and largest of the meas_len intervals that follow the first edge after start.
- R3: jit_uipp = floor((int_max - int_min) * 4096 / UI) in unsigned Q4.12, where UI is 488 cycles when t1_mode=0 and 647 cycles when t1_mode=1. A spread of 16 UI or more reads 0xFFFF.
- R4: The first edge after start yields time-error sample 0. Every later edge adds (interval - reference interval) to the running sum. mtie is the largest (max - min) over all windows of tau_len consecutive samples.
- R5: A constant interval offset of d cycles from the reference gives mtie = (tau_len - 1) * |d|, growing linearly with tau_len.
- R6: With rel_mode=1, the reference interval is the most recent interval measured between rising edges of master_clk, so equal clock rates give mtie=0.
- R7: done rises after the measurement period and its computations finish. It then stays high, with all results unchanged, until the next start.
- R8: A start pulse drops done on the next cycle and clears min, max, jitter and MTIE state, so a new run reports only its own intervals.
- R9: If the run produces fewer than tau_len samples, mtie is 0.
- R10: tau_len is clamped to the range 2 to 64, so a value of 0 behaves as 2.
- R11: Consecutive mon_clk rising edges must be more than tau_len + 2 cycles apart. Under that condition, no edge is lost to the window scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; timestamp time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: clear results and arm a run |
| t1_mode | input | 1 | 0 selects a 488-cycle UI, 1 selects a 647-cycle UI |
| rel_mode | input | 1 | 1 uses the master_clk interval as the reference |
| mon_clk | input | 1 | Monitored recovered clock, synchronous to clk |
| master_clk | input | 1 | Master clock for relative mode, synchronous to clk |
| meas_len | input | 16 | Intervals in the measurement period (at least 1) |
| tau_len | input | 7 | Observation window in time-error samples |
| done | output | 1 | Results are final |
| int_min | output | 32 | Shortest interval seen |
| int_max | output | 32 | Longest interval seen |
| jit_uipp | output | 16 | Peak-to-peak jitter, Q4.12 UI |
| mtie | output | 40 | Worst window peak-to-peak time error, cycles |

## Verification
The hardest result to reach is the sliding-window maximum. It differs from a plain min/max of all time-error samples only when the time error wanders back and forth over spans longer than tau_len. The stimulus therefore drives interval sequences whose running sum rises and then falls, so that the widest window sits in the middle of the run. A constant-offset stream is run at two values of tau_len to show the linear growth. The relative mode needs a concurrent master clock running before start, and the bench forks a master generator for that case.

// File: rtl/jitter_mtie_monitor.sv
module jitter_mtie_monitor #(
  parameter int TSW   = 32,
  parameter int TEW   = 40,
  parameter int DEPTH = 64,
  parameter int UI_E1 = 488,
  parameter int UI_T1 = 647,
  parameter int CNTW  = 16,
  parameter int FRAC  = 12,
  parameter int QW    = 16,
  parameter int TAUW  = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            t1_mode,
  input  logic            rel_mode,
  input  logic            mon_clk,
  input  logic            master_clk,
  input  logic [CNTW-1:0] meas_len,
  input  logic [TAUW-1:0] tau_len,
  output logic            done,
  output logic [TSW-1:0]  int_min,
  output logic [TSW-1:0]  int_max,
  output logic [QW-1:0]   jit_uipp,
  output logic [TEW-1:0]  mtie
);
  localparam int AW  = $clog2(DEPTH);
  localparam int EXT = TEW - TSW;
  localparam int NW  = TSW + FRAC;
  localparam int DBW = $clog2(QW);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_SCAN, S_PREP, S_DIV, S_DONE} st_t;
  st_t st;

  logic [TSW-1:0] ts, last_ts, m_last, m_int;
  logic           m_seen, m_valid, mon_q, mst_q;
  logic [CNTW-1:0] n_int;
  logic [TAUW:0]   n_smp;
  logic signed [TEW-1:0] te, wmin, wmax;
  logic signed [TEW-1:0] hist [DEPTH];
  logic [TAUW-1:0] idx;
  logic [NW-1:0]   num;
  logic [QW-1:0]   quo;
  logic [DBW-1:0]  dbit;

  wire mon_edge = mon_clk & ~mon_q;
  wire mst_edge = master_clk & ~mst_q;
  wire [TSW-1:0] nom_ui  = t1_mode ? TSW'(UI_T1) : TSW'(UI_E1);
  wire [TSW-1:0] ref_int = (rel_mode && m_valid) ? m_int : nom_ui;
  wire [TSW-1:0] ivl     = ts - last_ts;
  wire [TAUW-1:0] tau_eff = (tau_len < TAUW'(2)) ? TAUW'(2) :
                            (tau_len > TAUW'(DEPTH)) ? TAUW'(DEPTH) : tau_len;
  wire signed [TEW-1:0] te_next = te + $signed({{EXT{1'b0}}, ivl})
                                     - $signed({{EXT{1'b0}}, ref_int});
  wire signed [TEW-1:0] v  = hist[idx[AW-1:0]];
  wire signed [TEW-1:0] lo = (idx == '0 || v < wmin) ? v : wmin;
  wire signed [TEW-1:0] hi = (idx == '0 || v > wmax) ? v : wmax;
  wire [TEW-1:0] pp = TEW'(hi - lo);
  wire [TSW-1:0] spread = int_max - int_min;
  wire [NW-1:0]  den = NW'(nom_ui) << dbit;
  wire           take = (num >= den);
  wire [QW-1:0]  quo_n = quo | (QW'(take) << dbit);

  assign done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts <= '0; m_last <= '0; m_int <= '0; m_seen <= 1'b0; m_valid <= 1'b0;
      mon_q <= 1'b0; mst_q <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      mon_q <= mon_clk;
      mst_q <= master_clk;
      if (mst_edge) begin
        m_last <= ts;
        m_seen <= 1'b1;
        if (m_seen) begin
          m_int <= ts - m_last;
          m_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; last_ts <= '0; n_int <= '0; n_smp <= '0; te <= '0;
      wmin <= '0; wmax <= '0; idx <= '0; num <= '0; quo <= '0; dbit <= '0;
      int_min <= '1; int_max <= '0; jit_uipp <= '0; mtie <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (start) begin
      st <= S_RUN; n_int <= '0; n_smp <= '0; te <= '0;
      int_min <= '1; int_max <= '0; jit_uipp <= '0; mtie <= '0;
    end else begin
      case (st)
        S_RUN: if (mon_edge) begin
          last_ts <= ts;
          for (int i = DEPTH - 1; i > 0; i--) hist[i] <= hist[i-1];
          if (n_smp == '0) begin
            hist[0] <= '0;
            te <= '0;
            n_smp <= 1;
          end else begin
            hist[0] <= te_next;
            te <= te_next;
            n_int <= n_int + 1'b1;
            if (ivl < int_min) int_min <= ivl;
            if (ivl > int_max) int_max <= ivl;
            if (n_smp < (TAUW+1)'(DEPTH)) n_smp <= n_smp + 1'b1;
            if (n_smp + 1'b1 >= (TAUW+1)'(tau_eff)) begin
              st <= S_SCAN;
              idx <= '0;
            end else if (n_int + 1'b1 == meas_len) st <= S_PREP;
          end
        end
        S_SCAN: begin
          wmin <= lo;
          wmax <= hi;
          idx <= idx + 1'b1;
          if (idx == tau_eff - 1'b1) begin
            if (pp > mtie) mtie <= pp;
            st <= (n_int == meas_len) ? S_PREP : S_RUN;
          end
        end
        S_PREP: begin
          if (spread >= (nom_ui << 4)) begin
            jit_uipp <= '1;
            st <= S_DONE;
          end else begin
            num <= NW'(spread) << FRAC;
            quo <= '0;
            dbit <= DBW'(QW - 1);
            st <= S_DIV;
          end
        end
        S_DIV: begin
          if (take) num <= num - den;
          quo <= quo_n;
          dbit <= dbit - 1'b1;
          if (dbit == '0) begin
            jit_uipp <= quo_n;
            st <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(jit_uipp) && $stable(mtie) && $stable(int_min));
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && mtie == '0 && jit_uipp == '0);
  assert_minmax_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN || st == S_PREP) |-> int_min <= int_max);
  assert_scan_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SCAN |-> idx < tau_eff && n_smp >= (TAUW+1)'(tau_eff));
  assert_no_early_mtie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && n_smp < (TAUW+1)'(tau_eff)) |-> mtie == '0);
endmodule

// File: tb/jitter_mtie_monitor_tb.sv
module jitter_mtie_monitor_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, t1_mode = 1'b0, rel_mode = 1'b0;
  logic mon_clk = 1'b0, master_clk = 1'b0;
  logic [15:0] meas_len = 16'd1;
  logic [6:0]  tau_len = 7'd2;
  logic done;
  logic [31:0] int_min, int_max;
  logic [15:0] jit_uipp;
  logic [39:0] mtie;

  int n_chk = 0, n_bad = 0;
  int per [0:63];

  always #5 clk = ~clk;

  jitter_mtie_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .t1_mode(t1_mode), .rel_mode(rel_mode),
    .mon_clk(mon_clk), .master_clk(master_clk), .meas_len(meas_len), .tau_len(tau_len),
    .done(done), .int_min(int_min), .int_max(int_max), .jit_uipp(jit_uipp), .mtie(mtie));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_jit(input int n, input int ui);
    longint mn = per[0], mx = per[0], d;
    for (int k = 1; k < n; k++) begin
      if (per[k] < mn) mn = per[k];
      if (per[k] > mx) mx = per[k];
    end
    d = mx - mn;
    return (d >= 16 * ui) ? 65535 : (d * 4096) / ui;
  endfunction

  function automatic longint exp_mtie(input int n, input int refi, input int tau);
    longint te [0:64];
    longint best = 0, lo, hi;
    te[0] = 0;
    for (int k = 1; k <= n; k++) te[k] = te[k-1] + per[k-1] - refi;
    for (int j = 0; j + tau - 1 <= n; j++) begin
      lo = te[j]; hi = te[j];
      for (int m = j; m < j + tau; m++) begin
        if (te[m] < lo) lo = te[m];
        if (te[m] > hi) hi = te[m];
      end
      if (hi - lo > best) best = hi - lo;
    end
    return best;
  endfunction

  task automatic run(input int n, input int tau);
    meas_len = 16'(n);
    tau_len = 7'(tau);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    mon_clk = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk) mon_clk = 1'b0;
      repeat (per[k] - 1) @(negedge clk);
      mon_clk = 1'b1;
    end
    @(negedge clk) mon_clk = 1'b0;
    for (int w = 0; w < 3000 && !done; w++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 mtie", mtie, 0);
    check("R1 jit", jit_uipp, 0);
    check("R1 max", int_max, 0);
    check("R1 min", int_min, 32'hFFFF_FFFF);
  endtask

  task automatic t_e1_jitter();
    int p [0:9] = '{500, 476, 488, 500, 500, 500, 476, 476, 476, 488};
    for (int k = 0; k < 10; k++) per[k] = p[k];
    t1_mode = 1'b0; rel_mode = 1'b0;
    run(10, 4);
    check("R7 done", done, 1);
    check("R2 min", int_min, 476);
    check("R2 max", int_max, 500);
    check("R3 e1 jit", jit_uipp, exp_jit(10, 488));
    check("R3 e1 jit 201", jit_uipp, 201);
    check("R4 sliding mtie", mtie, exp_mtie(10, 488, 4));
  endtask

  task automatic t_linear();
    for (int k = 0; k < 16; k++) per[k] = 490;
    run(16, 4);
    check("R5 tau4", mtie, 6);
    check("R3 zero jit", jit_uipp, 0);
    run(16, 8);
    check("R5 tau8", mtie, 14);
    check("R8 new run min", int_min, 490);
    tau_len = 7'd0;
    run(16, 0);
    check("R10 tau clamp", mtie, 2);
  endtask

  task automatic t_t1();
    for (int k = 0; k < 8; k++) per[k] = (k % 2) ? 660 : 640;
    t1_mode = 1'b1;
    run(8, 3);
    check("R3 t1 jit", jit_uipp, 126);
    check("R4 t1 mtie", mtie, exp_mtie(8, 647, 3));
    t1_mode = 1'b0;
  endtask

  task automatic t_hold();
    longint j = jit_uipp, m = mtie;
    repeat (300) @(negedge clk);
    check("R7 hold done", done, 1);
    check("R7 hold jit", jit_uipp, j);
    check("R7 hold mtie", mtie, m);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R8 start drops done", done, 0);
    check("R8 start clears mtie", mtie, 0);
    check("R8 start clears max", int_max, 0);
  endtask

  task automatic t_relative(input int pm, input int pmon, input int tau, input longint expm);
    for (int k = 0; k < 10; k++) per[k] = pmon;
    rel_mode = 1'b1;
    fork
      begin
        for (int c = 0; c < 16; c++) begin
          @(negedge clk) master_clk = 1'b1;
          @(negedge clk) master_clk = 1'b0;
          repeat (pm - 2) @(negedge clk);
        end
      end
    join_none
    repeat (2 * pm + 10) @(negedge clk);
    run(10, tau);
    check("R6 relative mtie", mtie, expm);
    wait fork;
    rel_mode = 1'b0;
  endtask

  task automatic t_short();
    for (int k = 0; k < 3; k++) per[k] = 520;
    run(3, 8);
    check("R9 short run mtie", mtie, 0);
    check("R2 short max", int_max, 520);
  endtask

  task automatic t_sat();
    per[0] = 200; per[1] = 8200; per[2] = 200; per[3] = 8200;
    run(4, 2);
    check("R3 saturate", jit_uipp, 16'hFFFF);
    check("R11 large mtie", mtie, exp_mtie(4, 488, 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_e1_jitter();
    t_hold();
    t_linear();
    t_t1();
    t_relative(500, 500, 5, 0);
    t_relative(500, 503, 5, 12);
    t_short();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule